// File: doc/BRIEF.md
# Memory Module Control Register Bank

This block holds one 16-bit control word for each installed memory module, up to sixteen of them, and exposes them to a processor through a simple word-addressed slave port. A request lasts one cycle. Its response (ready strobe, read data and an error flag) comes back from registers in the next cycle. The register is selected by address bits [4:1], so the sixteen words sit two bytes apart inside a 32-byte window. All other address bits are ignored.

The number of registers that answer is set by the installed memory size. During reset the block takes the memory-size input, divides it by 256 KB and stores the result as the module count, saturated at sixteen. Any access whose index is equal to or above that count is answered with a non-existent-memory error and leaves every register unchanged. Only three control bits can be written: parity enable (bit 0), write wrong parity (bit 2) and extended register read enable (bit 14). Every other bit is stored and read as zero.

Top module: `memctl_csr_bank`

## Requirements
- R1: The register index is reqAddr[4:1]. Address bit 0 and bits 5 and up have no effect on which register is read or written.
- R2: A request sampled at a rising edge while reset is low produces rspReady high for exactly the following cycle. A valid read returns the stored 16-bit value of the indexed register with rspError low.
- R3: A read or write whose index is greater than or equal to the module count returns rspError high with rspRdata zero, and changes no register.
- R4: A valid write stores reqWdata AND 16'h4005: bit 0 parity enable, bit 2 write wrong parity, bit 14 extended read enable. All other bits are stored as zero, so a read never returns a one outside mask 16'h4005.
- R5: While rst is high, all sixteen registers clear to zero and rspReady stays low. A request presented in a reset cycle gets no response and writes nothing.
- R6: In each reset cycle the module count is loaded with memSizeBytes shifted right by 18, saturated at 16. A count of zero makes every access return an error.
- R7: After reset is released, the module count does not change, whatever memSizeBytes does.
- R8: rspReady is low in any cycle that does not follow a request. A valid write responds with rspError low and rspRdata zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; also loads the module count |
| memSizeBytes | input | 32 | Installed memory size in bytes |
| reqValid | input | 1 | Request strobe, one cycle per access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Byte address; bits [4:1] select the register |
| reqWdata | input | 16 | Write data |
| rspReady | output | 1 | Response strobe, the cycle after a request |
| rspRdata | output | 16 | Read data; zero for writes and errors |
| rspError | output | 1 | Non-existent-memory error for an out-of-range index |

## Verification
Reset and a bus request can arrive in the same cycle. In that case reset must win: no response strobe, and no trace of the write. The bench first loads a register with all writable bits set. It then raises reset in the same cycle as a write of all ones to that register, confirms that no response appears, and reads the register back as zero after release. A second overlap is between the latched module count and a memory-size input that changes after reset. The bench drives the input to its maximum mid-run and checks that an index above the latched count is still rejected.

// File: rtl/memctl_csr_pkg.sv
package memctl_csr_pkg;

  localparam int unsigned MAX_MODULES = 16;
  localparam int unsigned IDX_W       = $clog2(MAX_MODULES);
  localparam int unsigned CNT_W       = $clog2(MAX_MODULES + 1);
  localparam int unsigned CSR_W       = 16;

  // Writable control bits (R4)
  localparam int unsigned BIT_PARITY_EN   = 0;
  localparam int unsigned BIT_WRONG_PAR   = 2;
  localparam int unsigned BIT_EXT_READ_EN = 14;

  function automatic logic [CSR_W-1:0] writableMask();
    logic [CSR_W-1:0] m;
    m = '0;
    m[BIT_PARITY_EN]   = 1'b1;
    m[BIT_WRONG_PAR]   = 1'b1;
    m[BIT_EXT_READ_EN] = 1'b1;
    return m;
  endfunction

  localparam logic [CSR_W-1:0] WRITE_MASK = writableMask();

  // Strobes from control to datapath
  typedef struct packed {
    logic              wrEn;
    logic              rdEn;
    logic [IDX_W-1:0]  idx;
    logic [CSR_W-1:0]  wrData;
  } csrStrobe_t;

endpackage

// File: rtl/memctl_csr_ctrl.sv
module memctl_csr_ctrl
  import memctl_csr_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned SIZE_W       = 32,
  parameter int unsigned MODULE_SHIFT = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SIZE_W-1:0] memSizeBytes,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CSR_W-1:0]  reqWdata,
  output csrStrobe_t        strobe,
  output logic              rspReady,
  output logic              rspError,
  output logic [CNT_W-1:0]  modCount
);

  logic [SIZE_W-1:0] shiftedSize;
  logic [CNT_W-1:0]  sizeCount;
  logic [IDX_W-1:0]  reqIdx;
  logic              inRange;

  // Module count from size, saturated (R6)
  always_comb begin
    shiftedSize = memSizeBytes >> MODULE_SHIFT;
    if (shiftedSize > SIZE_W'(MAX_MODULES))
      sizeCount = CNT_W'(MAX_MODULES);
    else
      sizeCount = CNT_W'(shiftedSize);
  end

  // Word index from address bits [IDX_W:1] (R1)
  assign reqIdx  = reqAddr[IDX_W:1];
  assign inRange = CNT_W'(reqIdx) < modCount;

  always_comb begin
    strobe.wrEn   = reqValid && reqWrite  && inRange && !rst;
    strobe.rdEn   = reqValid && !reqWrite && inRange && !rst;
    strobe.idx    = reqIdx;
    strobe.wrData = reqWdata;
  end

  // Count is loaded only while reset is held (R6, R7)
  always_ff @(posedge clk) begin
    if (rst) begin
      modCount <= sizeCount;
      rspReady <= 1'b0;
      rspError <= 1'b0;
    end else begin
      rspReady <= reqValid;
      rspError <= reqValid && !inRange;
    end
  end

endmodule

// File: rtl/memctl_csr_regs.sv
module memctl_csr_regs
  import memctl_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  csrStrobe_t       strobe,
  output logic [CSR_W-1:0] rspRdata
);

  logic [CSR_W-1:0] csrView [MAX_MODULES];

  for (genvar gi = 0; gi < MAX_MODULES; gi++) begin : gCsr
    logic [CSR_W-1:0] csrQ;
    always_ff @(posedge clk) begin
      if (rst)
        csrQ <= '0;
      else if (strobe.wrEn && (strobe.idx == IDX_W'(gi)))
        csrQ <= strobe.wrData & WRITE_MASK;
    end
    assign csrView[gi] = csrQ;
  end

  // Read data is zero unless a valid read was accepted
  always_ff @(posedge clk) begin
    if (rst)
      rspRdata <= '0;
    else if (strobe.rdEn)
      rspRdata <= csrView[strobe.idx];
    else
      rspRdata <= '0;
  end

endmodule

// File: rtl/memctl_csr_bank.sv
module memctl_csr_bank
  import memctl_csr_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned SIZE_W       = 32,
  parameter int unsigned MODULE_SHIFT = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SIZE_W-1:0] memSizeBytes,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CSR_W-1:0]  reqWdata,
  output logic              rspReady,
  output logic [CSR_W-1:0]  rspRdata,
  output logic              rspError
);

  csrStrobe_t       strobe;
  logic [CNT_W-1:0] modCount;

  memctl_csr_ctrl #(
    .ADDR_W      (ADDR_W),
    .SIZE_W      (SIZE_W),
    .MODULE_SHIFT(MODULE_SHIFT)
  ) uCtrl (
    .clk         (clk),
    .rst         (rst),
    .memSizeBytes(memSizeBytes),
    .reqValid    (reqValid),
    .reqWrite    (reqWrite),
    .reqAddr     (reqAddr),
    .reqWdata    (reqWdata),
    .strobe      (strobe),
    .rspReady    (rspReady),
    .rspError    (rspError),
    .modCount    (modCount)
  );

  memctl_csr_regs uRegs (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .rspRdata(rspRdata)
  );

endmodule

// File: rtl/memctl_csr_bank_chk.sv
module memctl_csr_bank_chk
  import memctl_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspReady,
  input logic [CSR_W-1:0]  rspRdata,
  input logic              rspError,
  input logic [CNT_W-1:0]  modCount
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> rspReady);

  assert_no_spurious_rsp_R8: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !rspReady);

  assert_err_on_range_R3: assert property (@(posedge clk) disable iff (rst)
    (reqValid && (CNT_W'(reqAddr[IDX_W:1]) >= modCount)) |=> (rspError && rspRdata == '0));

  assert_err_only_with_rsp_R3: assert property (@(posedge clk) disable iff (rst)
    rspError |-> rspReady);

  assert_masked_data_R4: assert property (@(posedge clk) disable iff (rst)
    (rspRdata & ~WRITE_MASK) == '0);

  assert_count_limit_R6: assert property (@(posedge clk) disable iff (rst)
    armed |-> modCount <= CNT_W'(MAX_MODULES));

  assert_count_stable_R7: assert property (@(posedge clk) disable iff (rst)
    armed |-> $stable(modCount));

endmodule

bind memctl_csr_bank memctl_csr_bank_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk     (clk),
  .rst     (rst),
  .reqValid(reqValid),
  .reqAddr (reqAddr),
  .rspReady(rspReady),
  .rspRdata(rspRdata),
  .rspError(rspError),
  .modCount(uCtrl.modCount)
);

// File: tb/memctl_csr_bank_test.sv
`timescale 1ns/1ps
module memctl_csr_bank_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] memSizeBytes = 32'h0040_0000;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        rspReady;
  logic [15:0] rspRdata;
  logic        rspError;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        gotReady, gotErr;
  logic [15:0] gotData;

  always #4 clk = ~clk;

  memctl_csr_bank uut (
    .clk(clk), .rst(rst), .memSizeBytes(memSizeBytes),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rspReady(rspReady), .rspRdata(rspRdata),
    .rspError(rspError)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic applyReset(logic [31:0] size);
    @(negedge clk);
    rst = 1'b1;
    memSizeBytes = size;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic doReq(logic wr, logic [15:0] addr, logic [15:0] data);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = data;
    @(negedge clk);
    reqValid = 1'b0;
    gotReady = rspReady; gotErr = rspError; gotData = rspData();
  endtask

  function automatic logic [15:0] rspData();
    return rspRdata;
  endfunction

  function automatic logic [15:0] wordAddr(int idx);
    return 16'(idx << 1);
  endfunction

  // R5, R8: reset state and idle behaviour
  task automatic testResetState();
    applyReset(32'h0040_0000);
    @(negedge clk);
    check("R8 idle ready low", rspReady, 0);
    for (int i = 0; i < 16; i++) begin
      doReq(0, wordAddr(i), '0);
      check("R5 reg cleared", gotData, 16'h0000);
      check("R2 ready", gotReady, 1);
      check("R2 no error", gotErr, 0);
    end
    @(negedge clk);
    check("R8 single pulse", rspReady, 0);
  endtask

  // R4: write masking
  task automatic testMask();
    doReq(1, wordAddr(3), 16'hFFFF);
    check("R8 write ready", gotReady, 1);
    check("R8 write no error", gotErr, 0);
    check("R8 write data zero", gotData, 0);
    doReq(0, wordAddr(3), '0);
    check("R4 all ones masked", gotData, 16'h4005);
    doReq(1, wordAddr(3), 16'h1234);
    doReq(0, wordAddr(3), '0);
    check("R4 pattern masked", gotData, 16'h0004);
    doReq(1, wordAddr(3), 16'hBFFA);
    doReq(0, wordAddr(3), '0);
    check("R4 inverse masked", gotData, 16'h0000);
  endtask

  // R2: each register keeps its own value
  task automatic testDistinct();
    logic [15:0] pat [4] = '{16'h0001, 16'h0004, 16'h4000, 16'h4005};
    for (int i = 0; i < 16; i++) doReq(1, wordAddr(i), pat[i % 4]);
    for (int i = 0; i < 16; i++) begin
      doReq(0, wordAddr(i), '0);
      check("R2 read back", gotData, pat[i % 4]);
    end
  endtask

  // R1: only bits [4:1] select
  task automatic testDecode();
    doReq(1, 16'hFFE0 | wordAddr(5) | 16'h0001, 16'h4001);
    doReq(0, wordAddr(5), '0);
    check("R1 aliased write idx5", gotData, 16'h4001);
    doReq(0, wordAddr(4), '0);
    check("R1 neighbour idx4 untouched", gotData, 16'h0001);
    doReq(0, 16'h3A20 | wordAddr(5), '0);
    check("R1 aliased read idx5", gotData, 16'h4001);
  endtask

  // R3, R6: partial population
  task automatic testRange();
    applyReset(32'h000F_FFFF);  // 3 modules plus remainder
    doReq(1, wordAddr(0), 16'h0001);
    doReq(1, wordAddr(2), 16'h4000);
    doReq(0, wordAddr(2), '0);
    check("R6 idx2 valid", gotErr, 0);
    check("R2 idx2 data", gotData, 16'h4000);
    doReq(0, wordAddr(3), '0);
    check("R3 read idx3 error", gotErr, 1);
    check("R3 error ready", gotReady, 1);
    check("R3 error data zero", gotData, 0);
    doReq(1, wordAddr(3), 16'hFFFF);
    check("R3 write idx3 error", gotErr, 1);
    doReq(1, wordAddr(15) | 16'hFF00, 16'hFFFF);
    check("R3 write idx15 error", gotErr, 1);
    doReq(0, wordAddr(0), '0);
    check("R3 idx0 unchanged", gotData, 16'h0001);
    doReq(0, wordAddr(1), '0);
    check("R3 idx1 unchanged", gotData, 16'h0000);
    doReq(0, wordAddr(2), '0);
    check("R3 idx2 unchanged", gotData, 16'h4000);
    // R7: size input changes after reset
    memSizeBytes = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    doReq(0, wordAddr(5), '0);
    check("R7 count held idx5 error", gotErr, 1);
    doReq(0, wordAddr(2), '0);
    check("R7 idx2 still valid", gotErr, 0);
  endtask

  // R6: saturation and zero count
  task automatic testCountEdges();
    applyReset(32'hFFFF_FFFF);
    doReq(1, wordAddr(15), 16'h0005);
    doReq(0, wordAddr(15), '0);
    check("R6 saturated idx15 valid", gotErr, 0);
    check("R6 saturated idx15 data", gotData, 16'h0005);
    applyReset(32'h0003_FFFF);
    doReq(0, wordAddr(0), '0);
    check("R6 zero count idx0 error", gotErr, 1);
    applyReset(32'h0004_0000);
    doReq(0, wordAddr(0), '0);
    check("R6 one module idx0 ok", gotErr, 0);
    doReq(0, wordAddr(1), '0);
    check("R6 one module idx1 error", gotErr, 1);
  endtask

  // R5: reset overlapping a request
  task automatic testResetOverlap();
    applyReset(32'h0040_0000);
    doReq(1, wordAddr(1), 16'hFFFF);
    doReq(0, wordAddr(1), '0);
    check("R4 preload idx1", gotData, 16'h4005);
    @(negedge clk);
    rst = 1'b1;
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = wordAddr(1); reqWdata = 16'hFFFF;
    @(negedge clk);
    reqValid = 1'b0;
    check("R5 no response in reset", rspReady, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R5 no response after reset", rspReady, 0);
    doReq(0, wordAddr(1), '0);
    check("R5 cleared despite write", gotData, 16'h0000);
  endtask

  initial begin
    testResetState();
    testMask();
    testDistinct();
    testDecode();
    testRange();
    testCountEdges();
    testResetOverlap();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule